// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog timer. It counts pulses of a slow tick input and asks the chip for a reset when software stops servicing it in time. The timeout length comes from a 5-bit postscale code. Each code selects a power-of-two number of ticks, and codes past the largest supported exponent clamp to that exponent. The code is captured only while the block is held in reset, so it cannot change while a count is in progress.

Two static configuration inputs shape the behaviour. A lock input forces the watchdog on, and software then cannot turn it off. When the lock is low, the watchdog comes out of reset stopped, and software may start or stop it with a write strobe. A window input, active low, turns on window mode. In window mode, a service (clear) strobe that arrives before the last quarter of the timeout period is treated as a fault: it raises the reset request at once instead of restarting the count.

Expiry produces a one-cycle reset request and sets a sticky status flag. The flag stays set until the block is reset.

Top module: `wdt_win`

## Requirements
- R1: After a synchronous reset, `rst_req` and `timed_out` are 0, and `wd_active` equals `cfg_force_on`.
- R2: While active, the tick that brings the number of ticks since the last restart to 2^e raises `rst_req` for exactly the following cycle. Here e is the captured postscale code. A restart is a reset, an enable or an accepted clear.
- R3: A postscale code above MAX_CODE (default 20; code width 5 bits) behaves exactly like MAX_CODE.
- R4: `cfg_scale` is captured only while `rst` is 1. A change while running has no effect on the timeout length.
- R5: With `cfg_force_on` = 1, the watchdog stays active and counts even after software writes a disable.
- R6: With `cfg_force_on` = 0, the watchdog is inactive after reset. A `sw_wr_en` strobe with `sw_en_val` = 1 enables it, and with 0 disables it. While inactive, ticks and clears have no effect and no reset request is raised.
- R7: An accepted clear strobe returns the tick count to zero, so a full timeout period follows it.
- R8: With `cfg_win_off` = 0, a clear while the count is below L - max(L/4, 1) (L = 2^e) raises `rst_req` for the next cycle, leaves `timed_out` unchanged, and zeroes the count. A clear at or past that point is accepted normally. With `cfg_win_off` = 1, no clear is ever early.
- R9: `timed_out` is set only by expiry and stays 1 until reset.
- R10: A clear that coincides with the expiring tick wins, and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures `cfg_scale` |
| tick | input | 1 | Slow time-base pulse, one clock wide per tick |
| cfg_force_on | input | 1 | 1 locks the watchdog on |
| cfg_win_off | input | 1 | 0 enables window mode, 1 disables it |
| cfg_scale | input | CODE_W | Postscale code, exponent of the tick count |
| sw_wr_en | input | 1 | Software enable-write strobe |
| sw_en_val | input | 1 | Enable value written by `sw_wr_en` |
| sw_clear | input | 1 | Software service (clear) strobe |
| rst_req | output | 1 | One-cycle reset request |
| timed_out | output | 1 | Sticky expiry flag |
| wd_active | output | 1 | Watchdog is counting |

## Verification
The timeout length is tried with several postscale codes, each one tick short of expiry and then at expiry. The short run separates a correct count from an off-by-one, and codes above the clamp point separate clamping from plain power-of-two decoding. Clears are tried at counts just below and just at the window opening point, which separates early detection from normal servicing. They are also tried with window mode off, and on the exact tick of expiry. The lock and software-enable patterns show whether the enable rule is honoured. A scale change after reset shows that the captured code is held.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Outcome of one cycle of watchdog evaluation
    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_CLEAR  = 2'd1,
        EV_EARLY  = 2'd2,
        EV_EXPIRE = 2'd3
    } evt_e;

    // Clamp a postscale exponent to the largest supported value
    function automatic int unsigned clamp_exp(input int unsigned code,
                                              input int unsigned top);
        return (code > top) ? top : code;
    endfunction

endpackage

// File: rtl/wdt_span_decode.sv
module wdt_span_decode #(
    parameter int CODE_W   = 5,
    parameter int MAX_CODE = 20,
    parameter int CNT_W    = MAX_CODE + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  limit_o,
    output logic [CNT_W-1:0]  open_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  qtr;
    int unsigned       exp_v;

    // Code is held while the timer is out of reset
    always_ff @(posedge clk) begin
        if (rst) code_q <= code_i;
    end

    always_comb begin
        exp_v   = wdt_pkg::clamp_exp(32'(code_q), MAX_CODE);
        limit_o = ONE << exp_v;
        qtr     = limit_o >> 2;
        if (qtr == '0) qtr = ONE;
        open_o  = limit_o - qtr;
    end
endmodule

// File: rtl/wdt_enable.sv
module wdt_enable (
    input  logic clk,
    input  logic rst,
    input  logic force_on,
    input  logic wr_en,
    input  logic wr_val,
    output logic active
);
    logic sw_en_q;

    always_ff @(posedge clk) begin
        if (rst)        sw_en_q <= 1'b0;
        else if (wr_en) sw_en_q <= wr_val;
    end

    assign active = force_on | sw_en_q;
endmodule

// File: rtl/wdt_judge.sv
module wdt_judge #(
    parameter int CNT_W = 21
) (
    input  logic             active,
    input  logic             tick,
    input  logic             clear,
    input  logic             win_en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] limit,
    input  logic [CNT_W-1:0] open_at,
    output wdt_pkg::evt_e    ev
);
    always_comb begin
        ev = wdt_pkg::EV_NONE;
        if (active) begin
            if (clear) begin
                if (win_en && (cnt < open_at)) ev = wdt_pkg::EV_EARLY;
                else                           ev = wdt_pkg::EV_CLEAR;
            end else if (tick && (cnt == limit - CNT_W'(1))) begin
                ev = wdt_pkg::EV_EXPIRE;
            end
        end
    end
endmodule

// File: rtl/wdt_win.sv
module wdt_win #(
    parameter int CODE_W   = 5,
    parameter int MAX_CODE = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cfg_force_on,
    input  logic              cfg_win_off,
    input  logic [CODE_W-1:0] cfg_scale,
    input  logic              sw_wr_en,
    input  logic              sw_en_val,
    input  logic              sw_clear,
    output logic              rst_req,
    output logic              timed_out,
    output logic              wd_active
);
    localparam int CNT_W = MAX_CODE + 1;

    logic [CNT_W-1:0] limit, open_at, cnt_q;
    logic             req_q, flag_q, active;
    wdt_pkg::evt_e    ev;

    wdt_span_decode #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .CNT_W(CNT_W)) u_span (
        .clk(clk), .rst(rst), .code_i(cfg_scale),
        .limit_o(limit), .open_o(open_at)
    );

    wdt_enable u_en (
        .clk(clk), .rst(rst), .force_on(cfg_force_on),
        .wr_en(sw_wr_en), .wr_val(sw_en_val), .active(active)
    );

    wdt_judge #(.CNT_W(CNT_W)) u_judge (
        .active(active), .tick(tick), .clear(sw_clear), .win_en(~cfg_win_off),
        .cnt(cnt_q), .limit(limit), .open_at(open_at), .ev(ev)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            req_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            req_q <= 1'b0;
            case (ev)
                wdt_pkg::EV_EXPIRE: begin
                    cnt_q  <= '0;
                    req_q  <= 1'b1;
                    flag_q <= 1'b1;
                end
                wdt_pkg::EV_EARLY: begin
                    cnt_q <= '0;
                    req_q <= 1'b1;
                end
                wdt_pkg::EV_CLEAR: cnt_q <= '0;
                default: begin
                    if (!active)   cnt_q <= '0;
                    else if (tick) cnt_q <= cnt_q + CNT_W'(1);
                end
            endcase
        end
    end

    assign rst_req   = req_q;
    assign timed_out = flag_q;
    assign wd_active = active;
endmodule

// File: rtl/wdt_win_chk.sv
module wdt_win_chk (
    input logic clk,
    input logic rst,
    input logic cfg_force_on,
    input logic cfg_win_off,
    input logic sw_wr_en,
    input logic sw_en_val,
    input logic sw_clear,
    input logic rst_req,
    input logic timed_out,
    input logic wd_active
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!rst_req && !timed_out));

    // R5
    lock_on_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_force_on && sw_wr_en && !sw_en_val) |=> wd_active);

    // R9
    sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
        timed_out |=> timed_out);

    // R2
    req_needs_active_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(wd_active));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !wd_active |=> !rst_req);

    // R8, R10
    no_early_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_clear && cfg_win_off && wd_active) |=> !rst_req);

    // R9
    expiry_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_req && !$past(sw_clear)) |-> timed_out);
endmodule

bind wdt_win wdt_win_chk u_chk (
    .clk(clk), .rst(rst), .cfg_force_on(cfg_force_on), .cfg_win_off(cfg_win_off),
    .sw_wr_en(sw_wr_en), .sw_en_val(sw_en_val), .sw_clear(sw_clear),
    .rst_req(rst_req), .timed_out(timed_out), .wd_active(wd_active)
);

// File: tb/wdt_win_test.sv
module wdt_win_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC       = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       cfg_force_on = 1'b0;
    logic       cfg_win_off = 1'b1;
    logic [4:0] cfg_scale = 5'd0;
    logic       sw_wr_en = 1'b0;
    logic       sw_en_val = 1'b0;
    logic       sw_clear = 1'b0;
    logic       rst_req, timed_out, wd_active;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_win #(.CODE_W(5), .MAX_CODE(MAXC)) uut (
        .clk(clk), .rst(rst), .tick(tick), .cfg_force_on(cfg_force_on),
        .cfg_win_off(cfg_win_off), .cfg_scale(cfg_scale), .sw_wr_en(sw_wr_en),
        .sw_en_val(sw_en_val), .sw_clear(sw_clear), .rst_req(rst_req),
        .timed_out(timed_out), .wd_active(wd_active)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [4:0] code, input logic lock, input logic woff);
        @(negedge clk);
        cfg_scale = code; cfg_force_on = lock; cfg_win_off = woff; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        if (n > 0) begin
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic do_clear();
        sw_clear = 1'b1;
        @(negedge clk);
        sw_clear = 1'b0;
    endtask

    task automatic sw_write(input logic v);
        sw_wr_en = 1'b1; sw_en_val = v;
        @(negedge clk);
        sw_wr_en = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset(5'd3, 1'b0, 1'b1);
        chk("R1 req after reset", rst_req, 0);
        chk("R1 flag after reset", timed_out, 0);
        chk("R1 active follows lock=0", wd_active, 0);
        do_reset(5'd3, 1'b1, 1'b1);
        chk("R1 active follows lock=1", wd_active, 1);
    endtask

    task automatic t_scale(input logic [4:0] code);
        int lim = 1 << ((code > MAXC) ? MAXC : code);
        do_reset(code, 1'b1, 1'b1);
        run_ticks(lim - 1);
        chk($sformatf("R2 R3 no expiry before %0d ticks code %0d", lim, code), timed_out, 0);
        run_ticks(1);
        chk($sformatf("R2 R3 req at tick %0d code %0d", lim, code), rst_req, 1);
        chk("R9 flag set on expiry", timed_out, 1);
        @(negedge clk);
        chk("R2 req lasts one cycle", rst_req, 0);
        chk("R9 flag stays", timed_out, 1);
    endtask

    task automatic t_lock();
        do_reset(5'd2, 1'b1, 1'b1);
        sw_write(1'b0);
        chk("R5 active after sw disable", wd_active, 1);
        run_ticks(4);
        chk("R5 expiry while locked", rst_req, 1);
    endtask

    task automatic t_sw_enable();
        do_reset(5'd2, 1'b0, 1'b1);
        run_ticks(8);
        do_clear();
        chk("R6 no expiry while off", timed_out, 0);
        chk("R6 no req while off", rst_req, 0);
        sw_write(1'b1);
        chk("R6 enabled by write", wd_active, 1);
        run_ticks(3);
        chk("R6 no early expiry", timed_out, 0);
        run_ticks(1);
        chk("R6 expiry after enable", rst_req, 1);
        sw_write(1'b0);
        chk("R6 disabled by write", wd_active, 0);
    endtask

    task automatic t_scale_held();
        do_reset(5'd2, 1'b1, 1'b1);
        cfg_scale = 5'd6;
        run_ticks(3);
        chk("R4 no expiry at 3", timed_out, 0);
        run_ticks(1);
        chk("R4 captured code kept", rst_req, 1);
    endtask

    task automatic t_clear();
        do_reset(5'd3, 1'b1, 1'b1);
        run_ticks(6);
        do_clear();
        run_ticks(6);
        chk("R7 clear restarts count", timed_out, 0);
        run_ticks(1);
        tick = 1'b1; sw_clear = 1'b1;
        @(negedge clk);
        tick = 1'b0; sw_clear = 1'b0;
        chk("R10 clear beats final tick req", rst_req, 0);
        chk("R10 clear beats final tick flag", timed_out, 0);
        run_ticks(7);
        chk("R7 full period after clear", timed_out, 0);
        run_ticks(1);
        chk("R7 expiry after full period", rst_req, 1);
    endtask

    task automatic t_window();
        // L=8, window opens at count 6
        do_reset(5'd3, 1'b1, 1'b0);
        run_ticks(5);
        do_clear();
        chk("R8 early clear raises req", rst_req, 1);
        chk("R8 early clear leaves flag", timed_out, 0);
        @(negedge clk);
        chk("R8 early req one cycle", rst_req, 0);
        run_ticks(6);
        do_clear();
        chk("R8 clear at window start accepted", rst_req, 0);
        run_ticks(7);
        chk("R8 count restarted", timed_out, 0);
        run_ticks(1);
        chk("R8 expiry after accepted clear", rst_req, 1);
        do_reset(5'd3, 1'b1, 1'b1);
        run_ticks(1);
        do_clear();
        chk("R8 window off: early clear fine", rst_req, 0);
    endtask

    initial begin
        t_reset_state();
        t_scale(5'd0);
        t_scale(5'd4);
        t_scale(5'd9);
        t_scale(5'd10);
        t_scale(5'd17);
        t_scale(5'd31);
        t_lock();
        t_sw_enable();
        t_scale_held();
        t_clear();
        t_window();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule